// File: doc/BRIEF.md
# Prescaled Output-Compare Timer

This block is a 16-bit free-running up-counter driven through a power-of-two clock divider. It has a parameterised number of compare channels. A channel in compare mode watches the counter. In the cycle the counter steps onto the channel's target value, the channel raises its event flag and inverts its output pin. If the channel's interrupt enable is set, the flag also drives the shared interrupt line. Software gets evenly spaced events by adding a fixed step to the target after each event. Because the counter wraps modulo 2^16, the step keeps working across the wrap.

The divider and the clock-source selection sit behind a protection gate, so a stray write cannot retune or stop the timebase. The event flag has a two-step acknowledge: software first reads the channel control word while the flag is up, then writes zero to the flag bit. A write that was not preceded by such a read leaves the flag standing.

All registers are accessed through a simple synchronous port: one write strobe, one read strobe, an address and a data word. Read data appears one cycle after the read strobe.

Top module: `oc_timer`

## Requirements
- R1: The counter advances by exactly one per divided tick and wraps from 0xFFFF to 0x0000. A target moved forward by a step modulo 2^16 yields an event exactly step ticks after the previous one, across the wrap.
- R2: The divide field (timebase word at address 0, bits 2:0) divides the clock by 2 to the power of the field. From a reset divider, the k-th counter step lands k·2^field cycles after the clock is started.
- R3: The clock-source field (address 0, bits 4:3) runs the counter when it is 1 and freezes it for every other value, including 0. While frozen, the counter and the divider hold their values.
- R4: Writes to the timebase word take effect only while the unlock bit (address 1, bit 0) is 1. The unlock bit resets to 0, so a locked write leaves both the read-back and the counter unchanged.
- R5: A channel in compare mode (channel control bit 2 = 1) sets its flag (bit 0) in the same cycle the counter first shows the channel target. Channel n has its control word at address 4+2n and its target at address 5+2n.
- R6: The flag clears only when a read of that channel's control word sees the flag set and is followed by a write with bit 0 = 0. A write with bit 0 = 1, or a write that no such read preceded, leaves the flag at 1. A new event in the same cycle as the clearing write wins.
- R7: The interrupt output rises one cycle after any channel has both its flag and its enable (control bit 1) set, and it falls one cycle after no such channel remains.
- R8: Each channel's output pin toggles on each of its events, independently of the other channels.
- R9: A channel with compare mode 0 produces no flag and no pin toggle, even when the counter passes its target.
- R10: After reset the counter, the timebase word, the unlock bit, every channel word, the pins and the interrupt output are all 0.
- R11: Read data is registered and appears one cycle after the read strobe. Address 2 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the undivided timebase |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Registered read data |
| irq | output | 1 | Registered interrupt request |
| oc_pin | output | NUM_CH (2) | Per-channel toggling compare outputs |

## Verification
The hardest state to reach from the ports is an event just after the counter wraps. It needs about 65,000 cycles of running. The software step must also be written in the two cycles between one event and the counter passing the next target. The bench therefore runs at divide 1 with a target a few counts below 0xFFFF, rewrites the target as soon as it sees the pin toggle, and times the following toggle across the wrap.

The divide ratio is swept over all eight field values from a freshly reset divider, which makes the event cycle an exact product. The acknowledge protocol is probed through the interrupt pin, because reading the flag would itself arm the clear.

// File: rtl/oct_pkg.sv
package oct_pkg;
  // register map
  localparam int ADR_TIMEBASE = 0;
  localparam int ADR_UNLOCK   = 1;
  localparam int ADR_COUNT    = 2;
  localparam int ADR_CH_BASE  = 4;
  // timebase word fields
  localparam int TB_PS_LSB    = 0;
  localparam int TB_CS_LSB    = 3;
  localparam int CS_W         = 2;
  localparam logic [CS_W-1:0] CS_RUN = 2'd1;
  // channel control word bits
  localparam int CC_FLAG      = 0;
  localparam int CC_IE        = 1;
  localparam int CC_MODE      = 2;
endpackage

// File: rtl/oct_prescaler.sv
module oct_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < DIV_W; b++) mask[b] = (b < int'(ps));
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)      div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/oct_counter.sv
module oct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/oct_channel.sv
module oct_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ctrl_wr,
  input  logic             ctrl_rd,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic             flag,
  output logic             ie,
  output logic             mode,
  output logic [CNT_W-1:0] target,
  output logic             pin
);
  import oct_pkg::*;

  logic armed_q;
  logic hit;

  // event when the counter is about to step onto the target
  assign hit = tick && mode && (cnt_nxt == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      ie      <= 1'b0;
      mode    <= 1'b0;
      target  <= '0;
      pin     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (val_wr) target <= wdata;
      if (ctrl_wr) begin
        ie      <= wdata[CC_IE];
        mode    <= wdata[CC_MODE];
        armed_q <= 1'b0;
      end else if (ctrl_rd && flag) begin
        armed_q <= 1'b1;
      end
      if (hit) begin
        flag <= 1'b1;
        pin  <= ~pin;
      end else if (ctrl_wr && armed_q && !wdata[CC_FLAG]) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer #(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic [NUM_CH-1:0] oc_pin
);
  import oct_pkg::*;

  localparam int LAST_ADR = ADR_CH_BASE + 2 * NUM_CH - 1;

  logic                   wp_dis_q;
  logic [PS_W-1:0]        ps_q;
  logic [CS_W-1:0]        cs_q;
  logic                   tick;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       cnt_nxt;
  logic [NUM_CH-1:0]      ch_flag;
  logic [NUM_CH-1:0]      ch_ie;
  logic [NUM_CH-1:0]      ch_mode;
  logic [CNT_W-1:0]       ch_target [NUM_CH];
  logic [CNT_W-1:0]       rd_mux;

  // timebase and protection gate
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_dis_q <= 1'b0;
      ps_q     <= '0;
      cs_q     <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_UNLOCK)) wp_dis_q <= wdata[0];
      if (addr == ADDR_W'(ADR_TIMEBASE) && wp_dis_q) begin
        ps_q <= wdata[TB_PS_LSB +: PS_W];
        cs_q <= wdata[TB_CS_LSB +: CS_W];
      end
    end
  end

  oct_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst(rst), .run(cs_q == CS_RUN), .ps(ps_q), .tick(tick)
  );

  oct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int CTRL_ADR = ADR_CH_BASE + 2 * i;
    logic sel_ctrl, sel_val;
    assign sel_ctrl = (addr == ADDR_W'(CTRL_ADR));
    assign sel_val  = (addr == ADDR_W'(CTRL_ADR + 1));

    oct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .cnt_nxt(cnt_nxt),
      .ctrl_wr(wr_en && sel_ctrl), .ctrl_rd(rd_en && sel_ctrl),
      .val_wr(wr_en && sel_val), .wdata(wdata),
      .flag(ch_flag[i]), .ie(ch_ie[i]), .mode(ch_mode[i]),
      .target(ch_target[i]), .pin(oc_pin[i])
    );
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_TIMEBASE)) begin
      rd_mux[TB_PS_LSB +: PS_W] = ps_q;
      rd_mux[TB_CS_LSB +: CS_W] = cs_q;
    end else if (addr == ADDR_W'(ADR_UNLOCK)) begin
      rd_mux[0] = wp_dis_q;
    end else if (addr == ADDR_W'(ADR_COUNT)) begin
      rd_mux = cnt;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(addr) == ADR_CH_BASE + 2 * i) begin
        rd_mux[CC_FLAG] = ch_flag[i];
        rd_mux[CC_IE]   = ch_ie[i];
        rd_mux[CC_MODE] = ch_mode[i];
      end else if (int'(addr) == ADR_CH_BASE + 2 * i + 1) begin
        rd_mux = ch_target[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en && int'(addr) <= LAST_ADR) rdata <= rd_mux;
      irq <= |(ch_flag & ch_ie);
    end
  end
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0] flag,
  input logic [NUM_CH-1:0] ie,
  input logic [NUM_CH-1:0] mode,
  input logic [NUM_CH-1:0] pin,
  input logic              irq,
  input logic              wp_dis,
  input logic [PS_W-1:0]   ps,
  input logic [1:0]        cs
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs != 2'd1) |=> $stable(cnt));
  // R4
  locked_timebase_chk: assert property (@(posedge clk) disable iff (rst)
    !wp_dis |=> ($stable(ps) && $stable(cs)));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag & ie)) |=> irq);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flag & ie)) |=> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R8
    pin_on_event_chk: assert property (@(posedge clk) disable iff (rst)
      (pin[i] != $past(pin[i])) |-> flag[i]);
    // R9
    idle_channel_chk: assert property (@(posedge clk) disable iff (rst)
      !mode[i] |=> !$rose(flag[i]));
    // R6
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[i]) |-> $past(wr_en));
  end
endmodule

bind oc_timer oc_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cnt(cnt), .flag(ch_flag), .ie(ch_ie),
  .mode(ch_mode), .pin(oc_pin), .irq(irq), .wp_dis(wp_dis_q), .ps(ps_q), .cs(cs_q)
);

// File: tb/oc_timer_tb_top.sv
module oc_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [1:0]  oc_pin;

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .oc_pin(oc_pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int t0, t1, irq_at, irq_nx, cyc, ta, tb;
    logic p0, p1, seen1;

    // R10 reset state
    do_reset();
    rd(4'd0, v); chk(v == 0, "R10 timebase", v, 0);
    rd(4'd1, v); chk(v == 0, "R10 unlock", v, 0);
    rd(4'd2, v); chk(v == 0, "R10 count", v, 0);
    rd(4'd4, v); chk(v == 0, "R10 ch0 ctrl", v, 0);
    chk(irq == 0 && oc_pin == 0, "R10 pins", {irq, oc_pin}, 0);

    // R4 locked writes are dropped
    wr(4'd0, 16'h000A);
    repeat (20) @(negedge clk);
    rd(4'd0, v); chk(v == 0, "R4 locked timebase", v, 0);
    rd(4'd2, v); chk(v == 0, "R4 counter still stopped", v, 0);
    wr(4'd1, 16'h0001);
    rd(4'd1, v); chk(v == 1, "R11 unlock readback", v, 1);
    wr(4'd0, 16'h000A);
    rd(4'd0, v); chk(v == 16'h000A, "R4 unlocked timebase", v, 10);

    // R2 / R5 / R7 / R8 sweep over every divide value
    for (int p = 0; p < 8; p++) begin
      do_reset();
      wr(4'd1, 16'h0001);
      wr(4'd4, 16'h0004);   // ch0: compare, no interrupt
      wr(4'd5, 16'd3);
      wr(4'd6, 16'h0006);   // ch1: compare + interrupt
      wr(4'd7, 16'd5);
      wr(4'd0, 16'(8 | p));
      t0 = -1; t1 = -1; irq_at = -1; irq_nx = -1;
      p0 = oc_pin[0]; p1 = oc_pin[1];
      for (int c = 1; c <= (6 << p) + 2; c++) begin
        @(negedge clk);
        if (oc_pin[0] != p0 && t0 < 0) t0 = c;
        if (t1 >= 0 && c == t1 + 1) irq_nx = int'(irq);
        if (oc_pin[1] != p1 && t1 < 0) begin t1 = c; irq_at = int'(irq); end
      end
      chk(t0 == (3 << p), "R2 ch0 event cycle", t0, 3 << p);
      chk(t1 == (5 << p), "R8 ch1 event cycle", t1, 5 << p);
      chk(irq_at == 0, "R7 irq lag", irq_at, 0);
      chk(irq_nx == 1, "R7 irq raised", irq_nx, 1);
      rd(4'd4, v); chk(v == 16'h0005, "R5 ch0 flag", v, 5);
      rd(4'd6, v); chk(v == 16'h0007, "R5 ch1 flag", v, 7);
      // R3 freeze
      wr(4'd0, 16'(p));
      rd(4'd2, v);
      repeat (40) @(negedge clk);
      rd(4'd2, v2); chk(v2 == v, "R3 frozen count", v2, v);
    end

    // R6 acknowledge protocol, observed through irq
    do_reset();
    wr(4'd1, 16'h0001);
    wr(4'd4, 16'h0006);
    wr(4'd5, 16'd3);
    wr(4'd0, 16'h0008);
    repeat (10) @(negedge clk);
    chk(irq == 1, "R7 irq with enable", irq, 1);
    rd(4'd4, v); chk(v == 16'h0007, "R6 flag seen", v, 7);
    wr(4'd4, 16'h0007);
    @(negedge clk); chk(irq == 1, "R6 write-one keeps flag", irq, 1);
    wr(4'd4, 16'h0006);
    @(negedge clk); chk(irq == 1, "R6 unarmed write keeps flag", irq, 1);
    rd(4'd4, v); chk(v == 16'h0007, "R6 flag still set", v, 7);
    wr(4'd4, 16'h0006);
    rd(4'd4, v); chk(v == 16'h0006, "R6 flag cleared", v, 6);
    chk(irq == 0, "R7 irq dropped", irq, 0);

    // R1 wrap with software step, R9 disabled channel
    do_reset();
    wr(4'd1, 16'h0001);
    wr(4'd4, 16'h0004);
    wr(4'd5, 16'hFFF8);
    wr(4'd6, 16'h0000);
    wr(4'd7, 16'hFFF0);
    wr(4'd0, 16'h0008);
    cyc = 0; ta = -1; tb = -1; p0 = oc_pin[0]; seen1 = 1'b0;
    while (cyc < 65560) begin
      @(negedge clk); cyc++;
      if (oc_pin[1]) seen1 = 1'b1;
      if (oc_pin[0] != p0) begin
        p0 = oc_pin[0];
        if (ta < 0) begin
          ta = cyc;
          wr(4'd5, 16'h0008);
          cyc += 2;
        end else if (tb < 0) tb = cyc;
      end
    end
    chk(ta == 65528, "R1 event before wrap", ta, 65528);
    chk(tb == 65544, "R1 stepped event after wrap", tb, 65544);
    rd(4'd2, v); chk(v == 16'd25, "R1 count wrapped", v, 25);
    chk(seen1 == 0, "R9 idle pin", seen1, 0);
    rd(4'd6, v); chk(v == 0, "R9 idle flag", v, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule